// File: doc/BRIEF.md
# 90 kHz Media Clock Tick Generator

This block keeps a 32-bit media timestamp that advances at 90 kHz, paced by the nanosecond progress of a free-running time counter. The time counter supplies a small integer nanosecond step on every clock, usually 6 or 7 ns when the time base runs at 6.4 ns per cycle. The block adds each step into a sub-tick accumulator. Each time that accumulator reaches the integer tick interval of 11111 ns, the block removes one interval from it and advances the media count by one. Because the interval is applied by subtraction, the fractional remainder carries forward, and the long-run tick rate follows the time base.

When software loads the time base with an absolute value, the block rebuilds the media count from that time. The count becomes seconds times 90000 plus the whole number of tick intervals in the nanoseconds field. The accumulator takes the leftover nanoseconds. The division is done by a restoring divider over several cycles. A busy output is high while it runs, and during that time the count and accumulator are frozen. Offset corrections to the time base do not reload the count. They act only through the per-cycle step.

Top module: `media_tick_gen`

## Requirements
- R1: After reset, rtpCount is 0, busy is 0 and the sub-tick accumulator is 0.
- R2: In every cycle where busy is 0 and setStrobe is 0, nsDelta (an unsigned 3-bit value, 0 to 7) is added to the accumulator. A step of 0 leaves rtpCount unchanged.
- R3: When accumulator plus nsDelta is at least 11111, the accumulator becomes that sum minus 11111 and rtpCount rises by exactly one in the same cycle. A sum of exactly 11111 also ticks.
- R4: From a zero state, 100000 cycles of the repeating step pattern 6,6,7,6,7 (6.4 ns average) yield exactly 57 ticks. This is the 90 kHz rate at a 6.4 ns clock.
- R5: rtpCount wraps modulo 2^32. A tick from 0xFFFFFFFF gives 0.
- R6: A setStrobe accepted while idle loads rtpCount with (setSec*90000 + floor(setNsec/11111)) mod 2^32 and the accumulator with setNsec mod 11111. The new count appears after the edge that ends the busy period.
- R7: busy rises on the edge that accepts setStrobe and stays high for exactly 33 cycles. During that time, rtpCount holds and nsDelta is ignored.
- R8: A setStrobe that arrives while busy is 1 is ignored. The result is the one from the accepted set.
- R9: The count has no seconds-boundary logic. After an absolute set just below a second boundary, ticks continue one per 11111 ns of accumulated steps with no jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nsDelta | input | 3 | Integer nanoseconds the time base advanced this cycle |
| setStrobe | input | 1 | One-cycle request to rebuild the count from an absolute time |
| setSec | input | 48 | Seconds of the absolute time |
| setNsec | input | 32 | Nanoseconds of the absolute time |
| rtpCount | output | 32 | 90 kHz media timestamp |
| busy | output | 1 | High while the count is being rebuilt |

## Verification
Two corners are hard to reach: the 32-bit wrap and a tick landing exactly on the interval. Reaching the wrap by counting would take days of simulated ticks. The bench instead uses the absolute-set path to place the count at 0xFFFFFFFF with the accumulator one nanosecond short of the interval, then applies a single 1 ns step. That one step both wraps the count and tests the exact-equality tick. A second set is raised in the middle of a running rebuild, to show it is ignored. Throughout, a behavioural model checks the count and busy on every cycle.

// File: rtl/media_tick_pkg.sv
package media_tick_pkg;

  typedef struct packed {
    logic load;    // capture the absolute time and start the divider
    logic step;    // one divider iteration
    logic commit;  // write quotient and remainder into count and accumulator
    logic run;     // normal per-cycle accumulation
  } tick_ctrl_t;

endpackage

// File: rtl/media_tick_ctrl.sv
module media_tick_ctrl
  import media_tick_pkg::*;
#(
  parameter int NSEC_W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       setStrobe,
  output tick_ctrl_t ctrl,
  output logic       busy
);

  localparam int CNT_W = (NSEC_W > 1) ? $clog2(NSEC_W) : 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIV,
    ST_COMMIT
  } tick_state_e;

  tick_state_e state;
  logic [CNT_W-1:0] stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (setStrobe) begin
            state   <= ST_DIV;
            stepCnt <= '0;
          end
        end
        ST_DIV: begin
          if (stepCnt == CNT_W'(NSEC_W - 1)) begin
            state <= ST_COMMIT;
          end
          stepCnt <= stepCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load   = (state == ST_IDLE) && setStrobe;
    ctrl.run    = (state == ST_IDLE) && !setStrobe;
    ctrl.step   = (state == ST_DIV);
    ctrl.commit = (state == ST_COMMIT);
    busy        = (state != ST_IDLE);
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.load, ctrl.step, ctrl.commit, ctrl.run})) else $error("ctrl strobes overlap"); // R7

  AST_LOAD_TO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> busy) else $error("busy not raised after load"); // R7

  AST_COMMIT_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.commit |=> !busy) else $error("busy not dropped after commit"); // R7

  AST_SET_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.step && setStrobe) |=> busy) else $error("set during rebuild disturbed control"); // R8

endmodule

// File: rtl/media_tick_div.sv
module media_tick_div
  import media_tick_pkg::*;
#(
  parameter int NSEC_W    = 32,
  parameter int PERIOD_NS = 11111
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tick_ctrl_t           ctrl,
  input  logic [NSEC_W-1:0]    setNsec,
  output logic [NSEC_W-1:0]    quot,
  output logic [REM_W-1:0]     rem
);

  localparam int REM_W = $clog2(PERIOD_NS);

  logic [NSEC_W-1:0] dvd;
  logic [REM_W:0]    trial;
  logic              fits;

  always_comb begin
    trial = {rem, dvd[NSEC_W-1]};
    fits  = (trial >= (REM_W + 1)'(PERIOD_NS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dvd <= '0;
      rem <= '0;
    end else if (ctrl.load) begin
      dvd <= setNsec;
      rem <= '0;
    end else if (ctrl.step) begin
      if (fits) begin
        rem <= REM_W'(trial - (REM_W + 1)'(PERIOD_NS));
      end else begin
        rem <= trial[REM_W-1:0];
      end
      dvd <= {dvd[NSEC_W-2:0], fits};
    end
  end

  assign quot = dvd;

  AST_REM_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    rem < REM_W'(PERIOD_NS)) else $error("divider remainder out of range"); // R6

  AST_LOAD_CLEARS_REM: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> (rem == '0)) else $error("remainder not cleared on load"); // R6

endmodule

// File: rtl/media_tick_dp.sv
module media_tick_dp
  import media_tick_pkg::*;
#(
  parameter int DELTA_W   = 3,
  parameter int SEC_W     = 48,
  parameter int NSEC_W    = 32,
  parameter int CNT_W     = 32,
  parameter int PERIOD_NS = 11111,
  parameter int RATE_HZ   = 90000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tick_ctrl_t            ctrl,
  input  logic [DELTA_W-1:0]    nsDelta,
  input  logic [SEC_W-1:0]      setSec,
  input  logic [NSEC_W-1:0]     quot,
  input  logic [REM_W-1:0]      rem,
  output logic [CNT_W-1:0]      rtpCount
);

  localparam int REM_W = $clog2(PERIOD_NS);
  localparam int ACC_W = $clog2(PERIOD_NS + (1 << DELTA_W));

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;
  logic             wrapTick;
  logic [CNT_W-1:0] baseCount;
  logic [SEC_W-1:0] secProduct;

  always_comb begin
    sum        = acc + ACC_W'(nsDelta);
    wrapTick   = (sum >= ACC_W'(PERIOD_NS));
    secProduct = setSec * SEC_W'(RATE_HZ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCount <= '0;
    end else if (ctrl.load) begin
      baseCount <= secProduct[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      rtpCount <= '0;
    end else if (ctrl.commit) begin
      acc      <= ACC_W'(rem);
      rtpCount <= baseCount + CNT_W'(quot);
    end else if (ctrl.run) begin
      if (wrapTick) begin
        acc      <= sum - ACC_W'(PERIOD_NS);
        rtpCount <= rtpCount + 1'b1;
      end else begin
        acc <= sum;
      end
    end
  end

  AST_ACC_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    acc < ACC_W'(PERIOD_NS)) else $error("accumulator reached the interval"); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.run |=> (rtpCount == $past(rtpCount) || rtpCount == $past(rtpCount) + 1'b1))
    else $error("count moved by more than one"); // R3

  AST_HOLD_WHILE_DIV: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |=> $stable(rtpCount)) else $error("count moved during rebuild"); // R7

  AST_ZERO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.run && nsDelta == '0) |=> $stable(rtpCount)) else $error("count moved on zero step"); // R2

endmodule

// File: rtl/media_tick_gen.sv
module media_tick_gen
  import media_tick_pkg::*;
#(
  parameter int DELTA_W   = 3,
  parameter int SEC_W     = 48,
  parameter int NSEC_W    = 32,
  parameter int CNT_W     = 32,
  parameter int PERIOD_NS = 11111,
  parameter int RATE_HZ   = 90000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DELTA_W-1:0] nsDelta,
  input  logic               setStrobe,
  input  logic [SEC_W-1:0]   setSec,
  input  logic [NSEC_W-1:0]  setNsec,
  output logic [CNT_W-1:0]   rtpCount,
  output logic               busy
);

  localparam int REM_W = $clog2(PERIOD_NS);

  tick_ctrl_t        ctrl;
  logic [NSEC_W-1:0] quot;
  logic [REM_W-1:0]  rem;

  media_tick_ctrl #(
    .NSEC_W (NSEC_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .setStrobe (setStrobe),
    .ctrl      (ctrl),
    .busy      (busy)
  );

  media_tick_div #(
    .NSEC_W    (NSEC_W),
    .PERIOD_NS (PERIOD_NS)
  ) u_div (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .setNsec (setNsec),
    .quot    (quot),
    .rem     (rem)
  );

  media_tick_dp #(
    .DELTA_W   (DELTA_W),
    .SEC_W     (SEC_W),
    .NSEC_W    (NSEC_W),
    .CNT_W     (CNT_W),
    .PERIOD_NS (PERIOD_NS),
    .RATE_HZ   (RATE_HZ)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .nsDelta  (nsDelta),
    .setSec   (setSec),
    .quot     (quot),
    .rem      (rem),
    .rtpCount (rtpCount)
  );

endmodule

// File: tb/test_media_tick_gen.sv
`timescale 1ns/1ps
module test_media_tick_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  nsDelta = '0;
  logic        setStrobe = 1'b0;
  logic [47:0] setSec = '0;
  logic [31:0] setNsec = '0;
  logic [31:0] rtpCount;
  logic        busy;

  int nChk = 0;
  int nBad = 0;
  bit started = 0;
  bit finished = 0;
  string curReq = "R1";

  // behavioural reference
  longint unsigned mCount = 0;
  longint unsigned mAcc = 0;
  int              mPend = 0;
  longint unsigned tgtCount = 0;
  longint unsigned tgtAcc = 0;

  always #2 clk = ~clk;

  media_tick_gen i_media_tick_gen (
    .clk       (clk),
    .rstN      (rstN),
    .nsDelta   (nsDelta),
    .setStrobe (setStrobe),
    .setSec    (setSec),
    .setNsec   (setNsec),
    .rtpCount  (rtpCount),
    .busy      (busy)
  );

  function automatic longint unsigned expCount(longint unsigned s, longint unsigned n);
    longint unsigned lowSec = s % 64'h1_0000_0000;
    return (lowSec * 90000 + n / 11111) % 64'h1_0000_0000;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = 0; mAcc = 0; mPend = 0;
    end else if (mPend > 0) begin
      mPend--;
      if (mPend == 0) begin
        mCount = tgtCount;
        mAcc = tgtAcc;
      end
    end else if (setStrobe) begin
      mPend = 33;
      tgtCount = expCount(setSec, setNsec);
      tgtAcc = setNsec % 11111;
    end else begin
      mAcc += nsDelta;
      if (mAcc >= 11111) begin
        mAcc -= 11111;
        mCount = (mCount + 1) % 64'h1_0000_0000;
      end
    end
  end

  task automatic chk(string req, longint unsigned act, longint unsigned exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      chk(curReq, rtpCount, mCount);
      chk(curReq, busy, (mPend > 0) ? 1 : 0);
    end
  end

  task automatic run(int n, logic [2:0] d);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      nsDelta = d;
    end
  endtask

  task automatic runPattern(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (i % 5)
        2, 4:    nsDelta = 3'd7;
        default: nsDelta = 3'd6;
      endcase
    end
  endtask

  // absolute set; optional second request mid-rebuild
  task automatic doSet(logic [47:0] s, logic [31:0] n, bit interfere);
    longint unsigned e = expCount(s, n);
    @(negedge clk);
    setStrobe = 1'b1; setSec = s; setNsec = n; nsDelta = 3'd7;
    @(negedge clk);
    setStrobe = 1'b0;
    chk("R7", busy, 1);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (interfere && i == 4) begin
        setStrobe = 1'b1; setSec = 48'd777; setNsec = 32'd123456;
      end else begin
        setStrobe = 1'b0;
      end
      if (i == 31) chk("R7", busy, 1);
    end
    @(negedge clk);
    chk("R7", busy, 0);
    chk(interfere ? "R8" : "R6", rtpCount, e);
  endtask

  initial begin
    #(4 * 300000);
    nChk++; nBad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    longint unsigned held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    started = 1;
    @(negedge clk);
    chk("R1", rtpCount, 0);
    chk("R1", busy, 0);

    curReq = "R3";
    run(1600, 3'd7);
    chk("R3", rtpCount, 1);

    curReq = "R2";
    held = rtpCount;
    run(50, 3'd0);
    chk("R2", rtpCount, held);

    curReq = "R6";
    doSet(48'd0, 32'd0, 0);
    curReq = "R4";
    runPattern(100000);
    @(negedge clk);
    chk("R4", rtpCount, 57);

    curReq = "R6";
    doSet(48'd1, 32'd0, 0);
    doSet(48'd12345, 32'd500000000, 0);
    doSet(48'hFFFF_FFFF_FFFF, 32'd999999999, 0);
    doSet(48'd42, 32'hFFFF_FFFF, 0);

    curReq = "R8";
    doSet(48'd9, 32'd22222, 1);

    curReq = "R5";
    doSet(48'd47721, 32'd858835855, 0);
    chk("R5", rtpCount, 64'hFFFF_FFFF);
    run(1, 3'd1);
    @(negedge clk);
    chk("R5", rtpCount, 0);

    curReq = "R9";
    doSet(48'd5, 32'd999999990, 0);
    run(5000, 3'd7);
    @(negedge clk);
    chk("R9", rtpCount, (expCount(5, 999999990) + (999999990 % 11111 + 7 * 5001) / 11111) % 64'h1_0000_0000);

    finished = 1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule